// File: doc/BRIEF.md
# Active Picture Illegal Code Remapper

This block sits in a 10-bit component video word stream. It clamps the reserved codes at the top and bottom of the code space to the nearest legal value, but only for words inside the active picture. It finds the active picture itself by following timing reference sequences (TRS). A TRS is a preamble of three words, all-ones, zero, zero, followed by a status word. That status word marks either the start of active video (SAV) or the end of active video (EAV), and it carries a vertical-blanking bit.

Words outside the active picture always pass through unaltered: timing references, blanking and ancillary data, and lines in vertical blanking. A disable input turns the clamping off. Every word then passes through, with the same one-clock latency. A load strobe for a downstream FIFO is normally high. It drops for one clock beside the first active word of each line.

The tracker is a state machine with six states:
- `ST_SCAN`: outside the active picture.
- `ST_PRE1`: an all-ones word has been seen.
- `ST_PRE2`: the words all-ones, zero have been seen.
- `ST_XYZ`: the full preamble has been seen, and the next word is the status word.
- `ST_ACT_FIRST`: the next word is the first active word.
- `ST_ACT`: inside the active picture.

Each valid word drives one of these transitions:
- Any state goes to `ST_PRE1` on an all-ones word, except `ST_XYZ`.
- `ST_PRE1` goes to `ST_PRE2` on zero.
- `ST_PRE2` goes to `ST_XYZ` on zero.
- In `ST_PRE1` and `ST_PRE2`, any other word returns the tracker to `ST_SCAN`.
- `ST_XYZ` goes to `ST_ACT_FIRST` on an SAV with the vertical bit clear. Any other status word sends it to `ST_SCAN`.
- `ST_ACT_FIRST` goes to `ST_ACT` on any word that is not all-ones.
- `ST_ACT` stays in place on any word that is not all-ones.

Invalid cycles leave the state unchanged.

Top module: `illegal_code_remap`

## Requirements
- R1: While the word is inside the active picture and `remap_dis` is low, input values 3FCh to 3FEh leave as 3FBh. An all-ones word (3FFh) is never active, because it begins the next EAV preamble.
- R2: While the word is inside the active picture and `remap_dis` is low, input values 000h to 003h leave as 004h.
- R3: While `remap_dis` is high, every valid word leaves unchanged.
- R4: A word outside the active picture leaves unchanged, whatever its value.
- R5: `fifo_ld_n` goes low for exactly one clock, together with the output of the first active word of a line. This holds whether or not `remap_dis` is set. A line with no active words produces no strobe.
- R6: Latency is fixed at one clock. `out_vld` equals `vid_vld` of the previous cycle, and `out_word` holds its value after an invalid cycle. Invalid cycles inside a preamble do not break the preamble.
- R7: Values from 004h to 3FBh always leave unchanged.
- R8: The active picture starts with the valid word after a status word in which bit 6 (the H flag) is 0 (SAV) and bit 7 (the V flag) is 0. A status word with V=1, or with H=1 (EAV), starts no active picture.
- R9: A preamble counts only as the valid words 3FFh, 000h, 000h in sequence. Any other word inside the sequence returns the tracker to scanning. An all-ones word ends the active picture and passes unchanged.
- R10: While reset is asserted, `out_word` is 000h, `out_vld` is 0 and `fifo_ld_n` is 1. After reset, the tracker starts outside the active picture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_vld | input | 1 | Input word qualifier |
| vid_word | input | 10 | Input video word |
| remap_dis | input | 1 | High turns clamping off |
| out_word | output | 10 | Corrected word, one clock later |
| out_vld | output | 1 | Registered qualifier |
| fifo_ld_n | output | 1 | Load strobe, low beside the first active word |

## Verification
The bound checker watches several rules on every cycle:
- valid latency and holding of `out_word`;
- the top and bottom clamp values in the active states;
- unchanged data when the block is disabled, outside the active picture, or for mid-range codes;
- the single-cycle width of the load strobe;
- the allowed exits from scanning.

Whether the tracker places the region boundaries correctly shows only in the bench's line sequences. These cover SAV in vertical blanking, EAV, broken preambles, empty lines, gaps inside a preamble, and a reset in mid-line.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [2:0] {
        ST_SCAN,
        ST_PRE1,
        ST_PRE2,
        ST_XYZ,
        ST_ACT_FIRST,
        ST_ACT
    } trk_state_t;

endpackage

// File: rtl/trs_tracker.sv
module trs_tracker
    import remap_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word,
    output trk_state_t        state_o,
    output logic              in_active,
    output logic              first_word
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] ALL_ZERO = '0;
    localparam int                H_BIT    = DATA_W - 4;
    localparam int                V_BIT    = DATA_W - 3;

    trk_state_t state_q;
    trk_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (word_vld) begin
            unique case (state_q)
                ST_SCAN: begin
                    if (word == ALL_ONES) state_d = ST_PRE1;
                end
                ST_PRE1: begin
                    if (word == ALL_ZERO)      state_d = ST_PRE2;
                    else if (word == ALL_ONES) state_d = ST_PRE1;
                    else                       state_d = ST_SCAN;
                end
                ST_PRE2: begin
                    if (word == ALL_ZERO)      state_d = ST_XYZ;
                    else if (word == ALL_ONES) state_d = ST_PRE1;
                    else                       state_d = ST_SCAN;
                end
                ST_XYZ: begin
                    if (!word[H_BIT] && !word[V_BIT]) state_d = ST_ACT_FIRST;
                    else                              state_d = ST_SCAN;
                end
                ST_ACT_FIRST, ST_ACT: begin
                    if (word == ALL_ONES) state_d = ST_PRE1;
                    else                  state_d = ST_ACT;
                end
                default: state_d = ST_SCAN;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_active  = 1'b0;
        first_word = 1'b0;
        unique case (state_q)
            ST_ACT_FIRST: begin
                in_active  = word_vld && (word != ALL_ONES);
                first_word = word_vld && (word != ALL_ONES);
            end
            ST_ACT: begin
                in_active  = word_vld && (word != ALL_ONES);
            end
            default: begin
                in_active  = 1'b0;
                first_word = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/code_clamp.sv
module code_clamp #(
    parameter int DATA_W = 10
) (
    input  logic              clamp_en,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out
);

    localparam int                RSV_CODES = 1 << (DATA_W - 8);
    localparam logic [DATA_W-1:0] ALL_ONES  = '1;
    localparam logic [DATA_W-1:0] LO_LEGAL  = DATA_W'(RSV_CODES);
    localparam logic [DATA_W-1:0] HI_LEGAL  = ALL_ONES - DATA_W'(RSV_CODES);

    always_comb begin
        word_out = word_in;
        if (clamp_en) begin
            if (word_in < LO_LEGAL)      word_out = LO_LEGAL;
            else if (word_in > HI_LEGAL) word_out = HI_LEGAL;
        end
    end

endmodule

// File: rtl/illegal_code_remap.sv
module illegal_code_remap
    import remap_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_vld,
    input  logic [DATA_W-1:0] vid_word,
    input  logic              remap_dis,
    output logic [DATA_W-1:0] out_word,
    output logic              out_vld,
    output logic              fifo_ld_n
);

    trk_state_t        trk_state;
    logic              in_active;
    logic              first_word;
    logic [DATA_W-1:0] clamped;

    trs_tracker #(.DATA_W(DATA_W)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (vid_vld),
        .word      (vid_word),
        .state_o   (trk_state),
        .in_active (in_active),
        .first_word(first_word)
    );

    code_clamp #(.DATA_W(DATA_W)) u_clamp (
        .clamp_en(in_active && !remap_dis),
        .word_in (vid_word),
        .word_out(clamped)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_vld   <= 1'b0;
            fifo_ld_n <= 1'b1;
        end else begin
            out_vld   <= vid_vld;
            fifo_ld_n <= !first_word;
            if (vid_vld) out_word <= clamped;
        end
    end

endmodule

// File: rtl/remap_checker.sv
module remap_checker
    import remap_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vid_vld,
    input logic [DATA_W-1:0] vid_word,
    input logic              remap_dis,
    input logic [DATA_W-1:0] out_word,
    input logic              out_vld,
    input logic              fifo_ld_n,
    input trk_state_t        trk_state
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] LO_LEGAL = DATA_W'(1 << (DATA_W - 8));
    localparam logic [DATA_W-1:0] HI_LEGAL = ALL_ONES - DATA_W'(1 << (DATA_W - 8));

    logic act_st;
    assign act_st = (trk_state == ST_ACT) || (trk_state == ST_ACT_FIRST);

    AST_TOP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vld && !remap_dis && act_st && vid_word != ALL_ONES && vid_word > HI_LEGAL) |=> (out_word == HI_LEGAL)); // R1
    AST_BOTTOM_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vld && !remap_dis && act_st && vid_word < LO_LEGAL) |=> (out_word == LO_LEGAL)); // R2
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vld && remap_dis) |=> (out_word == $past(vid_word))); // R3
    AST_BLANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vld && !act_st) |=> (out_word == $past(vid_word))); // R4
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_ld_n |=> fifo_ld_n); // R5
    AST_LOAD_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_ld_n |-> out_vld); // R5
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        vid_vld |=> out_vld); // R6
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_vld |=> !out_vld); // R6
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_vld |=> $stable(out_word)); // R6
    AST_MID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vld && vid_word >= LO_LEGAL && vid_word <= HI_LEGAL) |=> (out_word == $past(vid_word))); // R7
    AST_SCAN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vld && trk_state == ST_SCAN) |=> (trk_state == ST_SCAN || trk_state == ST_PRE1)); // R9

endmodule

bind illegal_code_remap remap_checker #(.DATA_W(DATA_W)) u_remap_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_vld  (vid_vld),
    .vid_word (vid_word),
    .remap_dis(remap_dis),
    .out_word (out_word),
    .out_vld  (out_vld),
    .fifo_ld_n(fifo_ld_n),
    .trk_state(trk_state)
);

// File: tb/test_illegal_code_remap.sv
module test_illegal_code_remap;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_vld = 1'b0;
    logic [9:0] vid_word = '0;
    logic       remap_dis = 1'b0;
    logic [9:0] out_word;
    logic       out_vld;
    logic       fifo_ld_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    illegal_code_remap i_illegal_code_remap (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_vld  (vid_vld),
        .vid_word (vid_word),
        .remap_dis(remap_dis),
        .out_word (out_word),
        .out_vld  (out_vld),
        .fifo_ld_n(fifo_ld_n)
    );

    // {vld, dis, din, expected word, expected ld_n, requirement}
    localparam int NV = 59;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1,1'b0,10'h3FC,10'h3FC,1'b1,4'd4},  // R4 blank top code
        {1'b1,1'b0,10'h001,10'h001,1'b1,4'd4},  // R4 blank bottom code
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd9},  // R9 preamble
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd9},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd9},
        {1'b1,1'b0,10'h200,10'h200,1'b1,4'd8},  // R8 SAV, V=0
        {1'b1,1'b0,10'h3FD,10'h3FB,1'b0,4'd5},  // R5 first active word, R1
        {1'b1,1'b0,10'h002,10'h004,1'b1,4'd2},  // R2
        {1'b1,1'b0,10'h3FC,10'h3FB,1'b1,4'd1},  // R1
        {1'b1,1'b0,10'h000,10'h004,1'b1,4'd2},  // R2
        {1'b1,1'b0,10'h003,10'h004,1'b1,4'd2},  // R2
        {1'b1,1'b0,10'h004,10'h004,1'b1,4'd7},  // R7 edges
        {1'b1,1'b0,10'h3FB,10'h3FB,1'b1,4'd7},
        {1'b1,1'b0,10'h200,10'h200,1'b1,4'd7},
        {1'b0,1'b0,10'h3FE,10'h200,1'b1,4'd6},  // R6 hold on gap
        {1'b1,1'b0,10'h3FE,10'h3FB,1'b1,4'd1},  // R1
        {1'b1,1'b1,10'h001,10'h001,1'b1,4'd3},  // R3 disabled
        {1'b1,1'b1,10'h3FE,10'h3FE,1'b1,4'd3},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd9},  // R9 EAV preamble ends region
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd4},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd4},
        {1'b1,1'b0,10'h274,10'h274,1'b1,4'd8},  // R8 EAV
        {1'b1,1'b0,10'h3FE,10'h3FE,1'b1,4'd4},  // R4 horizontal blanking
        {1'b1,1'b0,10'h002,10'h002,1'b1,4'd4},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd8},  // R8 SAV with V=1
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd8},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd8},
        {1'b1,1'b0,10'h2AC,10'h2AC,1'b1,4'd8},
        {1'b1,1'b0,10'h3FD,10'h3FD,1'b1,4'd8},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd9},  // R9 broken preamble
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd9},
        {1'b1,1'b0,10'h001,10'h001,1'b1,4'd9},
        {1'b1,1'b0,10'h200,10'h200,1'b1,4'd9},
        {1'b1,1'b0,10'h002,10'h002,1'b1,4'd9},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd5},  // R5 empty line
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd5},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd5},
        {1'b1,1'b0,10'h200,10'h200,1'b1,4'd5},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd5},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd5},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd5},
        {1'b1,1'b0,10'h274,10'h274,1'b1,4'd5},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd4},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd5},  // R5 strobe while disabled
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd5},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd5},
        {1'b1,1'b0,10'h200,10'h200,1'b1,4'd5},
        {1'b1,1'b1,10'h3FE,10'h3FE,1'b0,4'd5},
        {1'b1,1'b0,10'h3FE,10'h3FB,1'b1,4'd1},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd6},  // R6 gap inside preamble
        {1'b0,1'b0,10'h123,10'h3FF,1'b1,4'd6},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd6},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd6},
        {1'b1,1'b0,10'h200,10'h200,1'b1,4'd6},
        {1'b1,1'b0,10'h001,10'h004,1'b0,4'd6},
        {1'b1,1'b0,10'h3FF,10'h3FF,1'b1,4'd9},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd9},
        {1'b1,1'b0,10'h000,10'h000,1'b1,4'd9},
        {1'b1,1'b0,10'h274,10'h274,1'b1,4'd9}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic d, input logic [9:0] w);
        vid_vld   = v;
        remap_dis = d;
        vid_word  = w;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        check("R10", "out_word", int'(out_word), 0);
        check("R10", "out_vld", int'(out_vld), 0);
        check("R10", "fifo_ld_n", int'(fifo_ld_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i][3:0]);
            send(VEC[i][26], VEC[i][25], VEC[i][24:15]);
            check(rq, $sformatf("out_word vec %0d", i), int'(out_word), int'(VEC[i][14:5]));
            check(rq, $sformatf("fifo_ld_n vec %0d", i), int'(fifo_ld_n), int'(VEC[i][4]));
            check("R6", $sformatf("out_vld vec %0d", i), int'(out_vld), int'(VEC[i][26]));
        end

        // R10 reset in mid-line returns tracker to scanning
        send(1'b1, 1'b0, 10'h3FF);
        send(1'b1, 1'b0, 10'h000);
        send(1'b1, 1'b0, 10'h000);
        send(1'b1, 1'b0, 10'h200);
        vid_vld = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "out_word in reset", int'(out_word), 0);
        check("R10", "fifo_ld_n in reset", int'(fifo_ld_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        send(1'b1, 1'b0, 10'h002);
        check("R10", "word after reset", int'(out_word), 'h002);
        check("R10", "no strobe after reset", int'(fifo_ld_n), 1);
        send(1'b0, 1'b0, 10'h000);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule